// File: doc/BRIEF.md
# Stall-Only Pipeline Hazard Controller

This block is the pipeline-register control for a five-stage in-order core (fetch, decode, execute, memory, writeback) that has no operand bypass network. It is purely combinational. From the opcode, register identifiers, branch outcome and status code held in each stage, it decides which pipeline registers hold their contents (stall) and which load a no-op (bubble). It also picks where the next instruction is fetched from.

Decode reads its operands only from the register file. Any read-after-write dependency therefore holds the instruction in decode until every in-flight producer has written back. A return holds fetch while its target is unknown. A conditional jump that was predicted taken but turns out not taken squashes the two younger instructions. An exceptional status in the memory or writeback stage freezes the tail of the pipeline and blocks condition-code updates.

Opcode encoding: halt 0, nop 1, reg-move 2, imm-move 3, store 4, load 5, alu 6, jump 7, call 8, return 9, push 10, pop 11. Status encoding: bubble 0, ok 1, halt 2, address error 3, invalid instruction 4. Register identifier all-ones (15 at default width) means "no register".

Top module: `hz_stall_ctrl`

## Requirements
- R1: For each of the five pipeline registers, stall and bubble are never both 1. The fetch bubble, execute stall, memory stall and writeback bubble are always 0.
- R2: When decode source A or source B equals any of the execute, memory or writeback destination identifiers (E or M write port), fetch stall, decode stall and execute bubble are 1, unless R7 applies.
- R3: The identifier 15 ("none") never creates a match, even when the source and the destination are both 15.
- R4: A load (5) or pop (11) in execute whose memory destination matches a decode source stalls decode. This holds even with a return (9) in decode, and decode bubble is then 0.
- R5: With a return (9) in decode, execute or memory and no data hazard, fetch stall and decode bubble are 1 and decode stall is 0.
- R6: A jump (7) in execute with condition 0 is a mispredict. It sets decode bubble and execute bubble.
- R7: On a mispredict, decode stall is 0 even when a data hazard is present.
- R8: pc_sel is 1 when memory holds a jump (7) with condition 0. Otherwise it is 2 when writeback holds a return (9). Otherwise it is 0.
- R9: A memory or writeback status of halt (2), address error (3) or invalid (4) sets memory bubble and clears cc_en. Bubble (0) and ok (1) statuses do neither.
- R10: Writeback stall is 1 exactly when the writeback status is halt, address error or invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_op | input | 4 | opcode in decode |
| d_src_a | input | REG_W | decode source A identifier |
| d_src_b | input | REG_W | decode source B identifier |
| e_op | input | 4 | opcode in execute |
| e_dst_e | input | REG_W | execute ALU-result destination |
| e_dst_m | input | REG_W | execute memory-result destination |
| e_cond | input | 1 | branch condition evaluated in execute |
| m_op | input | 4 | opcode in memory |
| m_cond | input | 1 | saved branch condition in memory |
| m_dst_e | input | REG_W | memory-stage ALU-result destination |
| m_dst_m | input | REG_W | memory-stage memory-result destination |
| m_status | input | 3 | status of the memory-stage instruction |
| w_op | input | 4 | opcode in writeback |
| w_dst_e | input | REG_W | writeback ALU-result destination |
| w_dst_m | input | REG_W | writeback memory-result destination |
| w_status | input | 3 | status in writeback |
| f_stall | output | 1 | hold fetch register |
| f_bubble | output | 1 | clear fetch register |
| d_stall | output | 1 | hold decode register |
| d_bubble | output | 1 | clear decode register |
| e_stall | output | 1 | hold execute register |
| e_bubble | output | 1 | clear execute register |
| m_stall | output | 1 | hold memory register |
| m_bubble | output | 1 | clear memory register |
| w_stall | output | 1 | hold writeback register |
| w_bubble | output | 1 | clear writeback register |
| pc_sel | output | 2 | 0 predicted, 1 fall-through of jump in memory, 2 return value |
| cc_en | output | 1 | condition codes may update |

## Verification
The bench aims at the overlap cases. A return in decode that is also load-dependent must stall, not bubble; getting this wrong would drop the return. A data hazard under a mispredict must not stall; getting this wrong would hold a squashed instruction. A mispredicted jump in memory together with a return in writeback must pick the fall-through address; a wrong priority would fetch from a stale stack value. A sweep over every register identifier against each of the six destination ports finds any port left out of the compare, and any comparison that lets the "none" identifier match and so stalls forever. It also catches a bubble status wrongly treated as an exception.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int OP_W = 4;
    localparam int ST_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_HALT = 4'd0,  OP_NOP  = 4'd1,  OP_RMOV = 4'd2,  OP_IMOV = 4'd3,
        OP_STOR = 4'd4,  OP_LOAD = 4'd5,  OP_ALU  = 4'd6,  OP_JMP  = 4'd7,
        OP_CALL = 4'd8,  OP_RET  = 4'd9,  OP_PUSH = 4'd10, OP_POP  = 4'd11
    } op_e;

    typedef enum logic [ST_W-1:0] {
        ST_BUB = 3'd0, ST_OK = 3'd1, ST_HLT = 3'd2, ST_ADR = 3'd3, ST_INV = 3'd4
    } st_e;

    typedef enum logic [1:0] {
        PC_PRED = 2'd0, PC_FALL = 2'd1, PC_RET = 2'd2
    } pcsel_e;

    typedef struct packed {
        logic   f_stall;
        logic   f_bubble;
        logic   d_stall;
        logic   d_bubble;
        logic   e_stall;
        logic   e_bubble;
        logic   m_stall;
        logic   m_bubble;
        logic   w_stall;
        logic   w_bubble;
        pcsel_e pc_sel;
        logic   cc_en;
    } ctrl_t;

    function automatic logic is_fault(input logic [ST_W-1:0] s);
        return (s == ST_HLT) || (s == ST_ADR) || (s == ST_INV);
    endfunction
endpackage

// File: rtl/hz_raw_detect.sv
module hz_raw_detect #(
    parameter int REG_W  = 4,
    parameter int N_DST  = 6
) (
    input  logic [REG_W-1:0]            src_a,
    input  logic [REG_W-1:0]            src_b,
    input  logic [N_DST-1:0][REG_W-1:0] dst,
    output logic                        hazard
);
    localparam logic [REG_W-1:0] NONE_ID = '1;

    logic [N_DST-1:0] hit_a;
    logic [N_DST-1:0] hit_b;

    for (genvar g = 0; g < N_DST; g++) begin : g_cmp
        assign hit_a[g] = (src_a != NONE_ID) && (src_a == dst[g]);
        assign hit_b[g] = (src_b != NONE_ID) && (src_b == dst[g]);
    end

    assign hazard = |{hit_a, hit_b};

    always_comb begin
        // R3
        if (!$isunknown({src_a, src_b}))
            none_no_match_chk: assert (!(src_a == NONE_ID && src_b == NONE_ID) || !hazard);
    end
endmodule

// File: rtl/hz_flow_events.sv
module hz_flow_events
    import hz_pkg::*;
(
    input  logic [OP_W-1:0] d_op,
    input  logic [OP_W-1:0] e_op,
    input  logic            e_cond,
    input  logic [OP_W-1:0] m_op,
    input  logic [ST_W-1:0] m_status,
    input  logic [ST_W-1:0] w_status,
    output logic            ret_busy,
    output logic            mispredict,
    output logic            fault_m,
    output logic            fault_w
);
    assign ret_busy   = (d_op == OP_RET) || (e_op == OP_RET) || (m_op == OP_RET);
    assign mispredict = (e_op == OP_JMP) && !e_cond;
    assign fault_m    = is_fault(m_status);
    assign fault_w    = is_fault(w_status);
endmodule

// File: rtl/hz_pc_select.sv
module hz_pc_select
    import hz_pkg::*;
(
    input  logic [OP_W-1:0] m_op,
    input  logic            m_cond,
    input  logic [OP_W-1:0] w_op,
    output pcsel_e          sel
);
    always_comb begin
        if (m_op == OP_JMP && !m_cond)
            sel = PC_FALL;
        else if (w_op == OP_RET)
            sel = PC_RET;
        else
            sel = PC_PRED;
    end
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
    import hz_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic [3:0]       d_op,
    input  logic [REG_W-1:0] d_src_a,
    input  logic [REG_W-1:0] d_src_b,
    input  logic [3:0]       e_op,
    input  logic [REG_W-1:0] e_dst_e,
    input  logic [REG_W-1:0] e_dst_m,
    input  logic             e_cond,
    input  logic [3:0]       m_op,
    input  logic             m_cond,
    input  logic [REG_W-1:0] m_dst_e,
    input  logic [REG_W-1:0] m_dst_m,
    input  logic [2:0]       m_status,
    input  logic [3:0]       w_op,
    input  logic [REG_W-1:0] w_dst_e,
    input  logic [REG_W-1:0] w_dst_m,
    input  logic [2:0]       w_status,
    output logic             f_stall,
    output logic             f_bubble,
    output logic             d_stall,
    output logic             d_bubble,
    output logic             e_stall,
    output logic             e_bubble,
    output logic             m_stall,
    output logic             m_bubble,
    output logic             w_stall,
    output logic             w_bubble,
    output logic [1:0]       pc_sel,
    output logic             cc_en
);
    localparam int N_DST = 6;

    logic                        raw_hz;
    logic                        ret_busy;
    logic                        mispredict;
    logic                        fault_m;
    logic                        fault_w;
    pcsel_e                      pc_choice;
    logic [N_DST-1:0][REG_W-1:0] dst_vec;
    ctrl_t                       ctrl_d;

    assign dst_vec = {w_dst_m, w_dst_e, m_dst_m, m_dst_e, e_dst_m, e_dst_e};

    hz_raw_detect #(.REG_W(REG_W), .N_DST(N_DST)) u_raw (
        .src_a  (d_src_a),
        .src_b  (d_src_b),
        .dst    (dst_vec),
        .hazard (raw_hz)
    );

    hz_flow_events u_evt (
        .d_op       (d_op),
        .e_op       (e_op),
        .e_cond     (e_cond),
        .m_op       (m_op),
        .m_status   (m_status),
        .w_status   (w_status),
        .ret_busy   (ret_busy),
        .mispredict (mispredict),
        .fault_m    (fault_m),
        .fault_w    (fault_w)
    );

    hz_pc_select u_pc (
        .m_op   (m_op),
        .m_cond (m_cond),
        .w_op   (w_op),
        .sel    (pc_choice)
    );

    always_comb begin
        logic hold_dec;
        hold_dec        = raw_hz && !mispredict;
        ctrl_d          = '0;
        ctrl_d.f_stall  = hold_dec || ret_busy;
        ctrl_d.d_stall  = hold_dec;
        ctrl_d.d_bubble = mispredict || (ret_busy && !raw_hz);
        ctrl_d.e_bubble = mispredict || raw_hz;
        ctrl_d.m_bubble = fault_m || fault_w;
        ctrl_d.w_stall  = fault_w;
        ctrl_d.pc_sel   = pc_choice;
        ctrl_d.cc_en    = !(fault_m || fault_w);
    end

    assign f_stall  = ctrl_d.f_stall;
    assign f_bubble = ctrl_d.f_bubble;
    assign d_stall  = ctrl_d.d_stall;
    assign d_bubble = ctrl_d.d_bubble;
    assign e_stall  = ctrl_d.e_stall;
    assign e_bubble = ctrl_d.e_bubble;
    assign m_stall  = ctrl_d.m_stall;
    assign m_bubble = ctrl_d.m_bubble;
    assign w_stall  = ctrl_d.w_stall;
    assign w_bubble = ctrl_d.w_bubble;
    assign pc_sel   = ctrl_d.pc_sel;
    assign cc_en    = ctrl_d.cc_en;

    always_comb begin
        if (!$isunknown({d_op, e_op, m_op, w_op, e_cond, m_cond, m_status, w_status})) begin
            // R1
            one_ctrl_per_reg_chk: assert (!(f_stall && f_bubble) && !(d_stall && d_bubble) &&
                                          !(e_stall && e_bubble) && !(m_stall && m_bubble) &&
                                          !(w_stall && w_bubble));
            // R7
            squash_no_hold_chk: assert (!mispredict || !d_stall);
            // R8
            ret_target_src_chk: assert (pc_sel != PC_RET || w_op == OP_RET);
            // R10
            tail_freeze_chk: assert (!w_stall || (m_bubble && !cc_en));
        end
    end
endmodule

// File: tb/sim_hz_stall_ctrl.sv
module sim_hz_stall_ctrl;
    localparam int N = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [3:0] d_op, e_op, m_op, w_op;
    logic [3:0] d_src_a, d_src_b, e_dst_e, e_dst_m, m_dst_e, m_dst_m, w_dst_e, w_dst_m;
    logic       e_cond, m_cond;
    logic [2:0] m_status, w_status;
    logic f_stall, f_bubble, d_stall, d_bubble, e_stall, e_bubble;
    logic m_stall, m_bubble, w_stall, w_bubble, cc_en;
    logic [1:0] pc_sel;

    hz_stall_ctrl u0 (.*);

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // stim: {d_op,srcA,srcB,e_op,e_dstE,e_dstM,e_cond,m_op,m_cond,m_dstE,m_dstM,m_st,w_op,w_dstE,w_dstM,w_st}
    localparam logic [55:0] STIM [N] = '{
        {4'h1,4'hF,4'hF, 4'h1,4'hF,4'hF,1'b1, 4'h1,1'b1,4'hF,4'hF,3'd1, 4'h1,4'hF,4'hF,3'd1}, // R1 idle
        {4'h6,4'h2,4'h3, 4'h3,4'h3,4'hF,1'b1, 4'h1,1'b1,4'hF,4'hF,3'd1, 4'h1,4'hF,4'hF,3'd1}, // R2 E dstE
        {4'h6,4'h2,4'hF, 4'h1,4'hF,4'hF,1'b1, 4'h6,1'b1,4'h2,4'hF,3'd1, 4'h1,4'hF,4'hF,3'd1}, // R2 M dstE
        {4'h6,4'hF,4'h5, 4'h1,4'hF,4'hF,1'b1, 4'h1,1'b1,4'hF,4'hF,3'd1, 4'h5,4'hF,4'h5,3'd1}, // R2 W dstM
        {4'h1,4'hF,4'hF, 4'h3,4'hF,4'hF,1'b1, 4'h6,1'b1,4'hF,4'hF,3'd1, 4'h5,4'hF,4'hF,3'd1}, // R3 none
        {4'h9,4'h4,4'hF, 4'h5,4'hF,4'h4,1'b1, 4'h1,1'b1,4'hF,4'hF,3'd1, 4'h1,4'hF,4'hF,3'd1}, // R4 load-use + ret
        {4'h9,4'hF,4'hF, 4'h1,4'hF,4'hF,1'b1, 4'h1,1'b1,4'hF,4'hF,3'd1, 4'h1,4'hF,4'hF,3'd1}, // R5 ret D
        {4'h1,4'hF,4'hF, 4'h1,4'hF,4'hF,1'b1, 4'h9,1'b1,4'hF,4'hF,3'd1, 4'h1,4'hF,4'hF,3'd1}, // R5 ret M
        {4'h6,4'h1,4'h2, 4'h7,4'hF,4'hF,1'b0, 4'h1,1'b1,4'hF,4'hF,3'd1, 4'h1,4'hF,4'hF,3'd1}, // R6 mispredict
        {4'h6,4'h2,4'hF, 4'h7,4'hF,4'hF,1'b0, 4'h6,1'b1,4'h2,4'hF,3'd1, 4'h1,4'hF,4'hF,3'd1}, // R7 misp+hazard
        {4'h1,4'hF,4'hF, 4'h1,4'hF,4'hF,1'b1, 4'h7,1'b0,4'hF,4'hF,3'd1, 4'h9,4'hF,4'hF,3'd1}, // R8 fall wins
        {4'h1,4'hF,4'hF, 4'h1,4'hF,4'hF,1'b1, 4'h7,1'b1,4'hF,4'hF,3'd1, 4'h9,4'hF,4'hF,3'd1}, // R8 ret
        {4'h1,4'hF,4'hF, 4'h1,4'hF,4'hF,1'b1, 4'h1,1'b1,4'hF,4'hF,3'd3, 4'h1,4'hF,4'hF,3'd1}, // R9 M adr
        {4'h1,4'hF,4'hF, 4'h1,4'hF,4'hF,1'b1, 4'h1,1'b1,4'hF,4'hF,3'd1, 4'h0,4'hF,4'hF,3'd2}, // R10 W halt
        {4'h1,4'hF,4'hF, 4'h1,4'hF,4'hF,1'b1, 4'h1,1'b1,4'hF,4'hF,3'd0, 4'h1,4'hF,4'hF,3'd4}, // R10 W inv, M bub
        {4'h9,4'hF,4'hF, 4'h7,4'hF,4'hF,1'b0, 4'h1,1'b1,4'hF,4'hF,3'd1, 4'h1,4'hF,4'hF,3'd1}  // R6 ret D + misp
    };
    // exp: {fS,fB,dS,dB,eS,eB,mS,mB,wS,wB,pc_sel,cc_en}
    localparam logic [12:0] EXP [N] = '{
        13'b0000000000_00_1, 13'b1010010000_00_1, 13'b1010010000_00_1, 13'b1010010000_00_1,
        13'b0000000000_00_1, 13'b1010010000_00_1, 13'b1001000000_00_1, 13'b1001000000_00_1,
        13'b0001010000_00_1, 13'b0001010000_00_1, 13'b0000000000_01_1, 13'b0000000000_10_1,
        13'b0000000100_00_0, 13'b0000000110_00_0, 13'b0000000110_00_0, 13'b1001010000_00_1
    };
    localparam string TAG [N] = '{"R1","R2","R2","R2","R3","R4","R5","R5",
                                  "R6","R7","R8","R8","R9","R10","R10","R6"};

    task automatic drive(input logic [55:0] v);
        {d_op, d_src_a, d_src_b, e_op, e_dst_e, e_dst_m, e_cond, m_op, m_cond,
         m_dst_e, m_dst_m, m_status, w_op, w_dst_e, w_dst_m, w_status} = v;
    endtask

    function automatic logic [12:0] observed();
        return {f_stall, f_bubble, d_stall, d_bubble, e_stall, e_bubble,
                m_stall, m_bubble, w_stall, w_bubble, pc_sel, cc_en};
    endfunction

    task automatic check(input string tag, input logic [12:0] exp);
        checks++;
        if (observed() !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, observed(), exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    localparam logic [55:0] IDLE = STIM[0];

    initial begin
        @(negedge clk);
        drive(IDLE);
        #2 check("R1 initial idle", EXP[0]);

        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            drive(STIM[i]);
            #2 check(TAG[i], EXP[i]);
        end

        // R2 / R3 sweep: each identifier against each of the six destination slots
        for (int id = 0; id < 16; id++) begin
            for (int slot = 0; slot < 6; slot++) begin
                logic [55:0] v;
                v = IDLE;
                v[51:48] = id[3:0];
                case (slot)
                    0: v[39:36] = id[3:0];
                    1: v[35:32] = id[3:0];
                    2: v[25:22] = id[3:0];
                    3: v[21:18] = id[3:0];
                    4: v[10:7]  = id[3:0];
                    default: v[6:3] = id[3:0];
                endcase
                @(negedge clk);
                drive(v);
                #2 check(id == 15 ? "R3 none sweep" : "R2 match sweep",
                         id == 15 ? 13'b0000000000_00_1 : 13'b1010010000_00_1);
            end
        end

        // R5 return in execute
        @(negedge clk);
        begin
            logic [55:0] v;
            v = IDLE;
            v[43:40] = 4'h9;
            drive(v);
        end
        #2 check("R5 ret in E", 13'b1001000000_00_1);

        // R4 pop in execute feeding srcB
        @(negedge clk);
        begin
            logic [55:0] v;
            v = IDLE;
            v[55:52] = 4'h9; v[47:44] = 4'h6; v[43:40] = 4'hB; v[35:32] = 4'h6;
            drive(v);
        end
        #2 check("R4 pop-use with ret", 13'b1010010000_00_1);

        // R9 memory ok status, writeback bubble status: no fault
        @(negedge clk);
        begin
            logic [55:0] v;
            v = IDLE;
            v[2:0] = 3'd0;
            drive(v);
        end
        #2 check("R9 bubble status harmless", 13'b0000000000_00_1);

        finish_run();
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule